// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts what happens in a processor or subsystem. It holds a small set of 32-bit event counters, `NCNT` by default 4, and one 64-bit cycle counter that lives at bit position 31 of every per-counter bit vector. Each event counter watches one of `NEVT` external event lines, and its type register picks the line. A counter whose type selects the software code can also be advanced by a register write. When a counter wraps, it sets its overflow status bit. A single level-sensitive interrupt is raised while any enabled, interrupt-enabled and implemented counter has overflow status pending.

Software reaches all state through a simple write port (`wr_en`, `wr_addr`, `wr_data`) and a combinational read port (`rd_addr` to `rd_data`). Enable, interrupt-enable and overflow state each sit behind a set/clear address pair, so one bit can be changed without a read-modify-write. A programmable counter-count field limits which counters may contribute to the interrupt. The asynchronous reset is released through a two-stage synchronizer, so the block leaves reset two clocks after `rst_n` rises.

Top module: `pmu_top`

## Requirements
- R1: The address map is as follows. Control is at 0x00 (bit 0 global enable, bit 1 event-counter reset, bit 2 cycle-counter reset, bit 6 long cycle, bits 15:11 counter count N, reset value `NCNT`; the reset bits read as 0). Counter enable set/clear are at 0x01/0x02. Interrupt enable set/clear are at 0x03/0x04. Overflow set/clear are at 0x05/0x06. Software increment is at 0x07. The cycle counter low and high words are at 0x08/0x09. Event counter i is at 0x20+i, and event type i is at 0x40+i. Bit i of every per-counter vector is event counter i, and bit 31 is the cycle counter.
- R2: The implemented-counter mask has bits N-1..0 set and bit 31 always set. When N is 0, only bit 31 is set.
- R3: `irq` is high exactly when the global enable is set and the AND of overflow status, counter enable, interrupt enable and the mask is nonzero. It is a level and drops once the contributing status bits are cleared.
- R4: A counter advances only while both the global enable and its own enable bit are set. Event counter i adds one in each such cycle in which `evt_in[type_i]` is high, provided type_i (the low 10 bits of its type register) is below `NEVT`. The cycle counter adds one every such cycle.
- R5: Writing control with bit 2 set zeroes the cycle counter. Writing control with bit 1 set zeroes every event counter.
- R6: With the long-cycle bit clear, the cycle counter sets overflow bit 31 when its low 32 bits wrap. With the bit set, it sets overflow bit 31 only when all 64 bits wrap.
- R7: An event counter that wraps past 0xFFFFFFFF sets its overflow status bit.
- R8: A software-increment write adds one to counter i only when bit i of the data is set, the counter is enabled (R4) and its type field is 0x000. Bit 31 and an all-zero write change nothing.
- R9: Set and clear addresses of a pair read back the same bits. Writing a 1 sets or clears that bit, and writing a 0 leaves it unchanged; this includes writing zero to overflow set. Bits of counters that are not present read 0.
- R10: When a software increment and a hardware event hit the same counter in one cycle, the counter advances by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| evt_in | input | NEVT | Event lines, one count per high cycle |
| irq | output | 1 | Level overflow interrupt |

## Verification
The hardest situations to reach are the 64-bit cycle-counter wrap and the case where a software increment and a hardware event land on the same counter in one cycle. For the wrap, the bench disables the cycle counter, loads both words to just below the wrap point, and then re-enables it, once in each long-cycle mode. For the coincidence, the bench drives `evt_in[0]` and a software-increment write in the same cycle onto a counter whose type is 0. A behavioural model tracks every register and the interrupt every cycle, so an off-by-one in any gating shows up as a mismatch.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int CYC_BIT   = 31;
  localparam int TYPE_W    = 10;
  localparam int NFIELD_W  = 5;

  localparam logic [ADDR_W-1:0] A_CTRL       = 8'h00;
  localparam logic [ADDR_W-1:0] A_CNTEN_SET  = 8'h01;
  localparam logic [ADDR_W-1:0] A_CNTEN_CLR  = 8'h02;
  localparam logic [ADDR_W-1:0] A_INTEN_SET  = 8'h03;
  localparam logic [ADDR_W-1:0] A_INTEN_CLR  = 8'h04;
  localparam logic [ADDR_W-1:0] A_OVF_SET    = 8'h05;
  localparam logic [ADDR_W-1:0] A_OVF_CLR    = 8'h06;
  localparam logic [ADDR_W-1:0] A_SWINC      = 8'h07;
  localparam logic [ADDR_W-1:0] A_CYC_LO     = 8'h08;
  localparam logic [ADDR_W-1:0] A_CYC_HI     = 8'h09;
  localparam logic [ADDR_W-1:0] A_EVCNT_BASE = 8'h20;
  localparam logic [ADDR_W-1:0] A_TYPE_BASE  = 8'h40;

  localparam int CB_EN    = 0;
  localparam int CB_EVRST = 1;
  localparam int CB_CYRST = 2;
  localparam int CB_LONG  = 6;
  localparam int CB_N_LSB = 11;

  localparam logic [TYPE_W-1:0] SW_CODE = '0;
endpackage

// File: rtl/pmu_evcnt.sv
module pmu_evcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         hw_inc,
  input  logic         sw_inc,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;
  logic         ce;

  always_comb begin
    sum   = {1'b0, cnt_q} + (W+1)'(hw_inc) + (W+1)'(sw_inc);
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = sum[W-1:0];
      wrap  = sum[W];
    end
  end

  assign ce = load | clr | hw_inc | sw_inc;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (ce)  cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pmu_cyccnt.sv
module pmu_cyccnt #(
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          inc,
  input  logic          clr,
  input  logic          load_lo,
  input  logic          load_hi,
  input  logic [HW-1:0] load_val,
  input  logic          long_mode,
  output logic [2*HW-1:0] cnt,
  output logic          wrap
);
  localparam int FW = 2 * HW;

  logic [FW-1:0] cnt_q, cnt_d;
  logic          ce;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (load_lo) begin
      cnt_d[HW-1:0] = load_val;
    end else if (load_hi) begin
      cnt_d[FW-1:HW] = load_val;
    end else if (clr) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = cnt_q + FW'(1);
      wrap  = long_mode ? (&cnt_q) : (&cnt_q[HW-1:0]);
    end
  end

  assign ce = load_lo | load_hi | clr | inc;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (ce)  cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pmu_top.sv
module pmu_top
  import pmu_pkg::*;
#(
  parameter int NCNT = 4,
  parameter int NEVT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [7:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic [NEVT-1:0]   evt_in,
  output logic              irq
);
  localparam int SEL_W = $clog2(NEVT);
  localparam logic [DATA_W-1:0] IMPL =
    (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NCNT) - DATA_W'(1));

  // reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // write decode
  logic wr_ctrl, wr_cen_s, wr_cen_c, wr_ien_s, wr_ien_c, wr_ovf_s, wr_ovf_c, wr_swinc;
  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_cen_s = wr_en && (wr_addr == A_CNTEN_SET);
  assign wr_cen_c = wr_en && (wr_addr == A_CNTEN_CLR);
  assign wr_ien_s = wr_en && (wr_addr == A_INTEN_SET);
  assign wr_ien_c = wr_en && (wr_addr == A_INTEN_CLR);
  assign wr_ovf_s = wr_en && (wr_addr == A_OVF_SET);
  assign wr_ovf_c = wr_en && (wr_addr == A_OVF_CLR);
  assign wr_swinc = wr_en && (wr_addr == A_SWINC);

  // control and bit-vector state
  logic                ctrl_en_q, ctrl_en_d;
  logic                long_q, long_d;
  logic [NFIELD_W-1:0] n_q, n_d;
  logic [DATA_W-1:0]   cnten_q, cnten_d, inten_q, inten_d, ovf_q, ovf_d;
  logic [DATA_W-1:0]   wrap_vec, valid_mask;
  logic                reg_ce;

  logic [DATA_W-1:0]   ev_cnt  [NCNT];
  logic [TYPE_W-1:0]   ev_type [NCNT];
  logic [NCNT-1:0]     ev_wrap;
  logic [2*DATA_W-1:0] cyc_cnt;
  logic                cyc_wrap;

  genvar gi;
  generate
    for (gi = 0; gi < NCNT; gi++) begin : g_ctr
      logic              cnt_on, hw_hit, sw_hit, wr_type, wr_cnt;
      logic [TYPE_W-1:0] type_q;

      assign wr_type = wr_en && (wr_addr == (A_TYPE_BASE + ADDR_W'(gi)));
      assign wr_cnt  = wr_en && (wr_addr == (A_EVCNT_BASE + ADDR_W'(gi)));
      assign cnt_on  = ctrl_en_q && cnten_q[gi];
      assign hw_hit  = cnt_on && (type_q < TYPE_W'(NEVT)) && evt_in[type_q[SEL_W-1:0]];
      assign sw_hit  = cnt_on && wr_swinc && wr_data[gi] && (type_q == SW_CODE);

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)      type_q <= '0;
        else if (wr_type) type_q <= wr_data[TYPE_W-1:0];
      end
      assign ev_type[gi] = type_q;

      pmu_evcnt #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_ni   (rst_ni),
        .hw_inc   (hw_hit),
        .sw_inc   (sw_hit),
        .clr      (wr_ctrl && wr_data[CB_EVRST]),
        .load     (wr_cnt),
        .load_val (wr_data),
        .cnt      (ev_cnt[gi]),
        .wrap     (ev_wrap[gi])
      );
    end
  endgenerate

  pmu_cyccnt #(.HW(DATA_W)) u_cyc (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .inc       (ctrl_en_q && cnten_q[CYC_BIT]),
    .clr       (wr_ctrl && wr_data[CB_CYRST]),
    .load_lo   (wr_en && (wr_addr == A_CYC_LO)),
    .load_hi   (wr_en && (wr_addr == A_CYC_HI)),
    .load_val  (wr_data),
    .long_mode (long_q),
    .cnt       (cyc_cnt),
    .wrap      (cyc_wrap)
  );

  always_comb begin
    wrap_vec = '0;
    for (int i = 0; i < NCNT; i++) wrap_vec[i] = ev_wrap[i];
    wrap_vec[CYC_BIT] = cyc_wrap;
  end

  always_comb begin
    valid_mask = '0;
    for (int i = 0; i < CYC_BIT; i++) valid_mask[i] = (NFIELD_W'(i) < n_q);
    valid_mask[CYC_BIT] = 1'b1;
  end

  // next state
  always_comb begin
    ctrl_en_d = ctrl_en_q;
    long_d    = long_q;
    n_d       = n_q;
    if (wr_ctrl) begin
      ctrl_en_d = wr_data[CB_EN];
      long_d    = wr_data[CB_LONG];
      n_d       = wr_data[CB_N_LSB +: NFIELD_W];
    end
    cnten_d = cnten_q;
    if (wr_cen_s) cnten_d = cnten_d | (wr_data & IMPL);
    if (wr_cen_c) cnten_d = cnten_d & ~wr_data;
    inten_d = inten_q;
    if (wr_ien_s) inten_d = inten_d | (wr_data & IMPL);
    if (wr_ien_c) inten_d = inten_d & ~wr_data;
    ovf_d = ovf_q;
    if (wr_ovf_s) ovf_d = ovf_d | (wr_data & IMPL);
    if (wr_ovf_c) ovf_d = ovf_d & ~wr_data;
    ovf_d = ovf_d | wrap_vec;
  end

  assign reg_ce = wr_en | (|wrap_vec);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q <= 1'b0;
      long_q    <= 1'b0;
      n_q       <= NFIELD_W'(NCNT);
      cnten_q   <= '0;
      inten_q   <= '0;
      ovf_q     <= '0;
    end else if (reg_ce) begin
      ctrl_en_q <= ctrl_en_d;
      long_q    <= long_d;
      n_q       <= n_d;
      cnten_q   <= cnten_d;
      inten_q   <= inten_d;
      ovf_q     <= ovf_d;
    end
  end

  assign irq = ctrl_en_q && (|(ovf_q & cnten_q & inten_q & valid_mask));

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:      rd_data = {16'h0, n_q, 4'h0, long_q, 5'h0, ctrl_en_q};
      A_CNTEN_SET,
      A_CNTEN_CLR: rd_data = cnten_q;
      A_INTEN_SET,
      A_INTEN_CLR: rd_data = inten_q;
      A_OVF_SET,
      A_OVF_CLR:   rd_data = ovf_q;
      A_CYC_LO:    rd_data = cyc_cnt[DATA_W-1:0];
      A_CYC_HI:    rd_data = cyc_cnt[2*DATA_W-1:DATA_W];
      default: begin
        for (int i = 0; i < NCNT; i++) begin
          if (rd_addr == (A_EVCNT_BASE + ADDR_W'(i))) rd_data = ev_cnt[i];
          if (rd_addr == (A_TYPE_BASE + ADDR_W'(i)))  rd_data = DATA_W'(ev_type[i]);
        end
      end
    endcase
  end
endmodule

// File: rtl/pmu_top_chk.sv
module pmu_top_chk
  import pmu_pkg::*;
(
  input logic        clk,
  input logic        rst_ni,
  input logic        wr_en,
  input logic [7:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        ctrl_en_q,
  input logic [31:0] cnten_q,
  input logic [31:0] inten_q,
  input logic [31:0] ovf_q,
  input logic [63:0] cyc_cnt,
  input logic        irq
);
  // R3: the interrupt needs the global enable
  assert_irq_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> ctrl_en_q);

  // R3: the interrupt needs a pending, enabled status bit
  assert_irq_needs_status_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    ((ovf_q & cnten_q & inten_q) == 32'h0) |-> !irq);

  // R4: with the global enable low and no writes, the cycle counter holds
  assert_cycle_frozen_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ctrl_en_q && !wr_en) |=> $stable(cyc_cnt));

  // R5: the cycle reset bit zeroes the cycle counter
  assert_cycle_reset_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && (wr_addr == A_CTRL) && wr_data[CB_CYRST]) |=> (cyc_cnt == 64'h0));

  // R9: writing zero to overflow set while idle leaves status unchanged
  assert_ovf_set_zero_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && (wr_addr == A_OVF_SET) && (wr_data == 32'h0) && !ctrl_en_q) |=> $stable(ovf_q));
endmodule

bind pmu_top pmu_top_chk u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .ctrl_en_q (ctrl_en_q),
  .cnten_q   (cnten_q),
  .inten_q   (inten_q),
  .ovf_q     (ovf_q),
  .cyc_cnt   (cyc_cnt),
  .irq       (irq)
);

// File: tb/pmu_top_tb.sv
module pmu_top_tb;
  localparam int NCNT = 4;
  localparam int NEVT = 8;
  localparam logic [31:0] IMPL = 32'h8000_0000 | ((32'h1 << NCNT) - 1);
  localparam logic [31:0] NF = 32'(NCNT) << 11;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [7:0]      wr_addr;
  logic [31:0]     wr_data;
  logic [7:0]      rd_addr;
  logic [31:0]     rd_data;
  logic [NEVT-1:0] evt_in;
  logic            irq;

  int checks = 0;
  int fails  = 0;
  bit chk_on = 1'b0;

  always #4 clk = ~clk;

  pmu_top #(.NCNT(NCNT), .NEVT(NEVT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_in(evt_in), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_ev [NCNT];
  logic [9:0]  m_type [NCNT];
  logic [63:0] m_cyc;
  logic [31:0] m_cnten, m_inten, m_ovf;
  logic [4:0]  m_n;
  bit          m_en, m_lc;

  function automatic logic [31:0] m_mask();
    logic [31:0] m = 32'h8000_0000;
    for (int i = 0; i < 31; i++) if (i < int'(m_n)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic bit m_irq();
    return m_en && ((m_ovf & m_cnten & m_inten & m_mask()) != 0);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r = 32'h0;
    case (a)
      8'h00: r = {16'h0, m_n, 4'h0, m_lc, 5'h0, m_en};
      8'h01, 8'h02: r = m_cnten;
      8'h03, 8'h04: r = m_inten;
      8'h05, 8'h06: r = m_ovf;
      8'h08: r = m_cyc[31:0];
      8'h09: r = m_cyc[63:32];
      default: for (int i = 0; i < NCNT; i++) begin
        if (int'(a) == 32 + i) r = m_ev[i];
        if (int'(a) == 64 + i) r = {22'h0, m_type[i]};
      end
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCNT; i++) begin m_ev[i] = 0; m_type[i] = 0; end
      m_cyc = 0; m_cnten = 0; m_inten = 0; m_ovf = 0; m_n = 5'(NCNT); m_en = 0; m_lc = 0;
    end else begin
      logic [31:0] wv;
      logic [31:0] nev [NCNT];
      logic [63:0] ncyc;
      wv = 0;
      for (int i = 0; i < NCNT; i++) begin
        int inc;
        longint s;
        inc = 0;
        if (m_en && m_cnten[i]) begin
          if (int'(m_type[i]) < NEVT && evt_in[m_type[i]]) inc++;
          if (wr_en && wr_addr == 8'h07 && wr_data[i] && m_type[i] == 0) inc++;
        end
        if (wr_en && int'(wr_addr) == 32 + i) nev[i] = wr_data;
        else if (wr_en && wr_addr == 8'h00 && wr_data[1]) nev[i] = 0;
        else begin
          s = longint'(m_ev[i]) + inc;
          if (s > 64'hFFFF_FFFF) wv[i] = 1'b1;
          nev[i] = s[31:0];
        end
      end
      ncyc = m_cyc;
      if (wr_en && wr_addr == 8'h08) ncyc[31:0] = wr_data;
      else if (wr_en && wr_addr == 8'h09) ncyc[63:32] = wr_data;
      else if (wr_en && wr_addr == 8'h00 && wr_data[2]) ncyc = 0;
      else if (m_en && m_cnten[31]) begin
        if (m_lc ? (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) : (m_cyc[31:0] == 32'hFFFF_FFFF)) wv[31] = 1'b1;
        ncyc = m_cyc + 1;
      end
      if (wr_en) begin
        case (wr_addr)
          8'h00: begin m_en = wr_data[0]; m_lc = wr_data[6]; m_n = wr_data[15:11]; end
          8'h01: m_cnten = m_cnten | (wr_data & IMPL);
          8'h02: m_cnten = m_cnten & ~wr_data;
          8'h03: m_inten = m_inten | (wr_data & IMPL);
          8'h04: m_inten = m_inten & ~wr_data;
          8'h05: m_ovf = m_ovf | (wr_data & IMPL);
          8'h06: m_ovf = m_ovf & ~wr_data;
          default: for (int i = 0; i < NCNT; i++)
            if (int'(wr_addr) == 64 + i) m_type[i] = wr_data[9:0];
        endcase
      end
      m_ovf = m_ovf | wv;
      for (int i = 0; i < NCNT; i++) m_ev[i] = nev[i];
      m_cyc = ncyc;
    end
  end

  // per-cycle comparison, sampled away from the edge
  always @(posedge clk) begin
    #2;
    if (chk_on) begin
      checks++;
      if (irq !== m_irq()) begin
        fails++;
        $display("FAIL R3 model irq: actual %0b expected %0b", irq, m_irq());
      end
      checks++;
      if (rd_data !== m_read(rd_addr)) begin
        fails++;
        $display("FAIL R1 model read @%h: actual %h expected %h", rd_addr, rd_data, m_read(rd_addr));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wait_evt(input logic [NEVT-1:0] v, input int n);
    @(negedge clk); evt_in = v;
    repeat (n) @(negedge clk);
    evt_in = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  logic [31:0] snap;

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; evt_in = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1'b1;

    // R1 reset state
    rd(8'h00, NF, "R1 ctrl reset");
    rd(8'h05, 32'h0, "R1 overflow reset");
    chk("R3 irq reset", 32'(irq), 32'h0);

    // R9 set/clear pairs
    wr(8'h01, 32'h8000_0003); rd(8'h01, 32'h8000_0003, "R9 enable set");
    rd(8'h02, 32'h8000_0003, "R9 clear reads same");
    wr(8'h01, 32'h0);          rd(8'h01, 32'h8000_0003, "R9 zero set no effect");
    wr(8'h02, 32'h1);          rd(8'h02, 32'h8000_0002, "R9 clear one bit");
    wr(8'h01, 32'hFFFF_FFFF);  rd(8'h01, IMPL, "R9 absent bits read 0");

    // R4 counting gate and event select
    wr(8'h40, 32'h1); wr(8'h41, 32'h2);
    wait_evt('1, 5);
    rd(8'h20, 32'h0, "R4 no count while disabled");
    rd(8'h08, 32'h0, "R4 cycle frozen while disabled");
    wr(8'h00, NF | 32'h1);
    wait_evt(8'h02, 3);
    rd(8'h20, 32'd3, "R4 event line count");
    rd(8'h21, 32'h0, "R4 other line ignored");
    wr(8'h00, NF);
    rd(8'h08, m_read(8'h08), "R4 cycle counted");
    snap = rd_data;
    wait_evt(8'h02, 4);
    rd(8'h20, 32'd3, "R4 held when global enable clear");
    rd(8'h08, snap, "R4 cycle held");

    // R7 wrap sets overflow, R3 irq level
    wr(8'h20, 32'hFFFF_FFFE); wr(8'h03, 32'h1); wr(8'h00, NF | 32'h1);
    wait_evt(8'h02, 2);
    rd(8'h20, 32'h0, "R7 counter wrapped");
    rd(8'h05, 32'h1, "R7 overflow bit set");
    chk("R3 irq asserted", 32'(irq), 32'h1);
    wr(8'h06, 32'h1);
    chk("R3 irq drops after clear", 32'(irq), 32'h0);

    // R2 mask, R3 enable gate, R9 zero set
    wr(8'h05, 32'h1);
    chk("R3 irq from set", 32'(irq), 32'h1);
    wr(8'h05, 32'h0); rd(8'h05, 32'h1, "R9 zero overflow set");
    wr(8'h00, 32'h1);
    chk("R2 N=0 masks counter 0", 32'(irq), 32'h0);
    wr(8'h00, (32'h1 << 11) | 32'h1);
    chk("R2 N=1 unmasks counter 0", 32'(irq), 32'h1);
    wr(8'h00, 32'h1 << 11);
    chk("R3 global enable gates irq", 32'(irq), 32'h0);
    wr(8'h06, 32'hFFFF_FFFF); rd(8'h05, 32'h0, "R9 clear all");

    // R8 software increment
    wr(8'h00, NF | 32'h1);
    wr(8'h07, 32'h4); rd(8'h22, 32'h1, "R8 type 0 increments");
    wr(8'h07, 32'h2); rd(8'h21, 32'h0, "R8 non-software type ignored");
    wr(8'h07, 32'h0); rd(8'h22, 32'h1, "R8 zero write no effect");
    wr(8'h02, 32'h4); wr(8'h07, 32'h4); rd(8'h22, 32'h1, "R8 disabled counter ignored");
    wr(8'h02, 32'h8000_0000);
    rd(8'h08, m_read(8'h08), "R8 cycle snapshot");
    snap = rd_data;
    wr(8'h07, 32'h8000_0000); rd(8'h08, snap, "R8 cycle not software incremented");

    // R10 coincident software and hardware increment
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'h07; wr_data = 32'h8; evt_in = 8'h01;
    @(negedge clk); wr_en = 1'b0; evt_in = '0;
    rd(8'h23, 32'h2, "R10 sum of both");

    // R5 control resets
    wr(8'h00, NF | 32'h7);
    rd(8'h20, 32'h0, "R5 event counter 0 cleared");
    rd(8'h23, 32'h0, "R5 event counter 3 cleared");
    rd(8'h08, 32'h0, "R5 cycle low cleared");
    rd(8'h09, 32'h0, "R5 cycle high cleared");
    rd(8'h00, NF | 32'h1, "R5 reset bits read 0");

    // R6 long cycle
    wr(8'h08, 32'hFFFF_FFFD); wr(8'h09, 32'h0); wr(8'h06, 32'hFFFF_FFFF);
    wr(8'h01, 32'h8000_0000); repeat (6) @(negedge clk);
    rd(8'h05, 32'h8000_0000, "R6 32-bit wrap flags");
    rd(8'h09, 32'h1, "R6 carry into high word");
    wr(8'h02, 32'h8000_0000);
    wr(8'h08, 32'hFFFF_FFFD); wr(8'h09, 32'h0); wr(8'h06, 32'hFFFF_FFFF);
    wr(8'h00, NF | 32'h41);
    wr(8'h01, 32'h8000_0000); repeat (6) @(negedge clk);
    rd(8'h05, 32'h0, "R6 long mode ignores low wrap");
    rd(8'h09, 32'h1, "R6 long mode carry");
    wr(8'h02, 32'h8000_0000);
    wr(8'h08, 32'hFFFF_FFFD); wr(8'h09, 32'hFFFF_FFFF);
    wr(8'h01, 32'h8000_0000); repeat (6) @(negedge clk);
    rd(8'h05, 32'h8000_0000, "R6 64-bit wrap flags");
    rd(8'h09, 32'h0, "R6 high word wrapped");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule